// File: doc/BRIEF.md
# Atomic Compare-And-Swap Bus Sequencer

This block lets a processor perform a semaphore-style compare-and-swap on a shared memory bus. The processor raises a one-cycle request with a target address, an expected value and a replacement value. The sequencer then takes the bus and holds it for the whole operation. It reads the addressed word and compares it with the expected value. Only when the two are equal does it write the replacement value back to the same address. The replacement value is usually the identifier of the task claiming ownership.

The bus cycle signal stays asserted from the first read strobe until the write is acknowledged, so no other master can slip an access in between. If the compare fails, the bus is dropped straight after the read and no write strobe is issued. In both cases the processor receives a one-cycle completion pulse, together with the word that was in memory and a flag that tells whether the swap took place.

Top module: `cas_sequencer`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `bus_cyc`, `bus_stb`, `bus_we`, `done` and `busy` are all low.
- R2: A `req` sampled high while idle starts a read on the next cycle: `bus_cyc`=1, `bus_stb`=1, `bus_we`=0, and `bus_adr` equals the `addr` given with the request.
- R3: A strobe, whether read or write, stays asserted with unchanged address and direction until the slave returns `bus_ack`. A slave inserting N wait states sees N+1 strobe cycles.
- R4: When the word read equals `cmp_val`, exactly one write is issued. It goes to the same address and carries `swap_val`.
- R5: When the word read differs from `cmp_val`, no write strobe is issued and `bus_cyc` is low in the cycle where `done` is high.
- R6: `bus_cyc` is never deasserted between the start of the read and the acknowledgement of the write. It falls only in the cycle where `done` is high.
- R7: `bus_adr` does not change while `bus_cyc` stays high.
- R8: `done` is high for exactly one cycle per operation. In that cycle `old_value` holds the word read, and `success` is 1 exactly when a write was made.
- R9: A `req` made while `busy`, and any change on `addr`, `cmp_val` or `swap_val` after the request cycle, has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a compare-and-swap (sampled while idle) |
| addr | input | ADDR_W | Target word address |
| cmp_val | input | DATA_W | Value expected in memory |
| swap_val | input | DATA_W | Value written on a match |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| old_value | output | DATA_W | Word read from memory, valid with done |
| success | output | 1 | Swap performed, valid with done |
| bus_cyc | output | 1 | Bus cycle, held across read and write |
| bus_stb | output | 1 | Transfer strobe |
| bus_we | output | 1 | Write enable |
| bus_adr | output | ADDR_W | Bus address |
| bus_dat_w | output | DATA_W | Write data |
| bus_dat_r | input | DATA_W | Read data |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
The bench covers the boundary between a match and a mismatch, including operands that differ in a single bit. A design that compared the wrong bits would write on a mismatch, or skip the write on a match. It varies the slave's wait states, from zero up to long stalls, on both the read and the write. A design that dropped its strobe early, or dropped `bus_cyc` between the phases, would show the wrong strobe counts or a gap in the cycle. It also raises `req` again and changes the operands while an operation is in flight. A design that re-sampled them would write the wrong data or address, or start a second operation.

// File: rtl/cas_sequencer.sv
module cas_sequencer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic [DATA_W-1:0] swap_val,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] old_value,
  output logic              success,
  output logic              bus_cyc,
  output logic              bus_stb,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_adr,
  output logic [DATA_W-1:0] bus_dat_w,
  input  logic [DATA_W-1:0] bus_dat_r,
  input  logic              bus_ack
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CMP, S_WRITE, S_DONE} st_t;

  st_t st, st_nx;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] cmp_q, swp_q, old_q;
  logic              ok_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (req) st_nx = S_READ;
      S_READ:  if (bus_ack) st_nx = S_CMP;
      S_CMP:   st_nx = (old_q == cmp_q) ? S_WRITE : S_DONE;
      S_WRITE: if (bus_ack) st_nx = S_DONE;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      adr_q <= '0;
      cmp_q <= '0;
      swp_q <= '0;
      old_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && req) begin
        adr_q <= addr;
        cmp_q <= cmp_val;
        swp_q <= swap_val;
      end
      if (st == S_READ && bus_ack) old_q <= bus_dat_r;
      if (st == S_CMP) ok_q <= (old_q == cmp_q);
    end
  end

  assign bus_cyc   = (st == S_READ) || (st == S_CMP) || (st == S_WRITE);
  assign bus_stb   = (st == S_READ) || (st == S_WRITE);
  assign bus_we    = (st == S_WRITE);
  assign bus_adr   = adr_q;
  assign bus_dat_w = swp_q;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign old_value = old_q;
  assign success   = ok_q;

endmodule

module cas_sequencer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              bus_cyc,
  input logic              bus_stb,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_adr,
  input logic              bus_ack
);

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && !bus_ack) |=> (bus_stb && $stable(bus_we) && $stable(bus_adr)));

  // R5
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_cyc);

  // R6
  cyc_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cyc) |-> done);

  // R7
  adr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |=> (!bus_cyc || $stable(bus_adr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_stb && bus_cyc));

endmodule

bind cas_sequencer cas_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
  .bus_we(bus_we), .bus_adr(bus_adr), .bus_ack(bus_ack)
);

// File: tb/cas_sequencer_tb.sv
`timescale 1ns/1ps
module cas_sequencer_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] cmp_val = '0, swap_val = '0;
  logic busy, done, success, bus_cyc, bus_stb, bus_we;
  logic [DW-1:0] old_value, bus_dat_w;
  logic [AW-1:0] bus_adr;
  logic [DW-1:0] bus_dat_r = '0;
  logic bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  cas_sequencer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .cmp_val(cmp_val),
    .swap_val(swap_val), .busy(busy), .done(done), .old_value(old_value),
    .success(success), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .bus_ack(bus_ack)
  );

  int tests = 0, fails = 0;
  logic [DW-1:0] mem [16];
  int wait_rd = 0, wait_wr = 0, stb_cnt = 0;
  int rd_stbs = 0, wr_stbs = 0, wr_count = 0;
  logic [AW-1:0] wr_adr, rd_adr;
  logic [DW-1:0] wr_dat;
  logic in_op = 1'b0, gap = 1'b0, adr_moved = 1'b0, started = 1'b0;
  int cycles = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit exp_ok(input logic [DW-1:0] cur, input logic [DW-1:0] c);
    return cur == c;
  endfunction

  function automatic logic [DW-1:0] exp_mem(input logic [DW-1:0] cur, input logic [DW-1:0] c,
                                            input logic [DW-1:0] s);
    return (cur == c) ? s : cur;
  endfunction

  // slave and bus monitor, acting away from the active edge
  always @(negedge clk) begin
    if (in_op) begin
      if (bus_cyc) begin
        if (started && bus_adr != rd_adr) adr_moved = 1'b1;
        if (!started) rd_adr = bus_adr;
        started = 1'b1;
      end else if (started && !done) gap = 1'b1;
    end
    if (bus_ack) begin
      bus_ack = 1'b0;
      stb_cnt = 0;
    end else if (bus_cyc && bus_stb) begin
      if (bus_we) wr_stbs++; else rd_stbs++;
      if (stb_cnt == (bus_we ? wait_wr : wait_rd)) begin
        bus_ack = 1'b1;
        if (bus_we) begin
          mem[bus_adr[3:0]] = bus_dat_w;
          wr_count++;
          wr_adr = bus_adr;
          wr_dat = bus_dat_w;
        end else bus_dat_r = mem[bus_adr[3:0]];
      end else stb_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_cas(input logic [3:0] a, input logic [DW-1:0] c, input logic [DW-1:0] s,
                         input int wr, input int ww, input bit disturb);
    logic [DW-1:0] cur;
    bit eo;
    int n;
    cur = mem[a];
    eo = exp_ok(cur, c);
    wait_rd = wr; wait_wr = ww;
    rd_stbs = 0; wr_stbs = 0; wr_count = 0;
    gap = 0; adr_moved = 0; started = 0;
    @(negedge clk);
    in_op = 1;
    req = 1; addr = {28'h0, a}; cmp_val = c; swap_val = s;
    @(negedge clk);
    chk(bus_cyc && bus_stb && !bus_we && bus_adr == {28'h0, a}, "R2 read start", bus_adr, a);
    if (disturb) begin
      req = 1; addr = addr ^ 32'h5; cmp_val = ~c; swap_val = ~s;
    end else req = 0;
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    req = 0;
    chk(old_value == cur, "R8 old_value", old_value, cur);
    chk(success == eo, "R8 success", success, eo);
    chk(!bus_cyc, "R5/R6 bus released at done", bus_cyc, 0);
    chk(rd_stbs == wr + 1, "R3 read strobe cycles", rd_stbs, wr + 1);
    chk(!gap, "R6 cyc continuous", gap, 0);
    chk(!adr_moved, "R7 address stable", adr_moved, 0);
    if (eo) begin
      chk(wr_count == 1 && wr_adr == {28'h0, a} && wr_dat == s, "R4 single write", wr_dat, s);
      chk(wr_stbs == ww + 1, "R3 write strobe cycles", wr_stbs, ww + 1);
    end else
      chk(wr_count == 0 && wr_stbs == 0, "R5 no write on mismatch", wr_count, 0);
    chk(mem[a] == exp_mem(cur, c, s), "R9 memory result", mem[a], exp_mem(cur, c, s));
    in_op = 0;
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    if (disturb) chk(!busy && !bus_cyc, "R9 request while busy ignored", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = 32'h100 + i;
    repeat (3) @(negedge clk);
    chk(!bus_cyc && !bus_stb && !bus_we && !done && !busy, "R1 reset state", {bus_cyc, bus_stb, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_cyc && !busy && !done, "R1 idle after reset", busy, 0);
    run_cas(4'd3, 32'h103, 32'hAA, 0, 0, 0);   // match, no waits
    run_cas(4'd3, 32'h103, 32'hBB, 0, 0, 0);   // now mismatch
    run_cas(4'd5, 32'h104, 32'hCC, 3, 0, 0);   // one-bit difference
    run_cas(4'd7, 32'h107, 32'hDD, 5, 7, 0);   // long waits on both phases
    run_cas(4'd9, 32'h109, 32'hEE, 1, 2, 1);   // disturbed inputs, match
    run_cas(4'd2, 32'hFFFF, 32'h11, 2, 0, 1);  // disturbed inputs, mismatch
    for (int k = 0; k < 150; k++) begin
      logic [3:0] a;
      logic [DW-1:0] c;
      a = 4'($urandom_range(0, 15));
      c = ($urandom_range(0, 1) == 1) ? mem[a] : mem[a] ^ (32'h1 << $urandom_range(0, 31));
      run_cas(a, c, $urandom, $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 3) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule